// File: doc/BRIEF.md
# 16-Bit Register-Pair Adder

This block is the combinational arithmetic path used when an 8-bit processor core adds or subtracts a 16-bit register pair. It takes a destination value, a source value, the current flag byte and an operation select. It returns the 16-bit result and the new flag byte in the same cycle. Register selection and the write-back into the register file belong to the surrounding datapath.

Three operations are provided: a plain add, an add that also takes in the incoming carry, and a subtract that also takes in the incoming borrow. They differ in how much of the flag byte they rewrite. The plain add keeps sign, zero and parity/overflow as they were and updates only carry, the half-carry and the subtract marker. The carry variants rebuild sign, zero, overflow and carry from the 16-bit result. A fourth select code leaves the destination and the flag byte unchanged.

The flag byte holds S in bit 7, Z in bit 6, H in bit 4, P/V in bit 2, N in bit 1 and C in bit 0. Bits 5 and 3 are unused. The select codes are 0 for the plain add, 1 for the add with carry, 2 for the subtract with borrow and 3 for the pass-through.

Top module: `reg_pair_adder`

## Requirements
- R1: With op_sel_i = 0 the result is (dst_i + src_i) mod 65536, and C (bit 0) equals the carry out of bit 15.
- R2: With op_sel_i = 0, bits 7 (S), 6 (Z) and 2 (P/V) of flags_o are copied from flags_i, and N (bit 1) is 0.
- R3: With op_sel_i = 1 the result is (dst_i + src_i + flags_i[0]) mod 65536, and C equals the carry out of bit 15.
- R4: With op_sel_i = 1 or 2, Z (bit 6) is 1 exactly when the 16-bit result is zero, and S (bit 7) equals result bit 15.
- R5: With op_sel_i = 1, V (bit 2) equals bit 15 of (NOT(dst XOR src) AND (result XOR dst)).
- R6: With op_sel_i = 2 the result is (dst_i - src_i - flags_i[0]) mod 65536, C is 1 exactly when dst_i < src_i + flags_i[0], and N is 1.
- R7: With op_sel_i = 2, V (bit 2) equals bit 15 of ((dst XOR src) AND (result XOR dst)).
- R8: With op_sel_i = 0, 1 or 2, H (bit 4) equals bit 12 of (dst XOR src XOR result), which is the carry or borrow out of bit 11.
- R9: With op_sel_i = 0, 1 or 2, flag bits 5 and 3 are 0. With op_sel_i = 1, N is 0.
- R10: With op_sel_i = 3 the result equals dst_i and flags_o equals flags_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 16 | Destination register-pair value (left operand) |
| src_i | input | 16 | Source register-pair value (right operand) |
| flags_i | input | 8 | Incoming flag byte; bit 0 is the carry or borrow in |
| op_sel_i | input | 2 | Operation select: 0 add, 1 add with carry, 2 subtract with borrow, 3 pass-through |
| result_o | output | 16 | 16-bit result |
| flags_o | output | 8 | Updated flag byte |

## Verification
Whenever the inputs settle, the assertions check four relations between the result port and the flag port: plain add leaves S, Z and P/V alone, the zero and sign flags of the carry variants track the result, the unused bits stay clear, and the subtract marker is set on subtraction. They cannot tell whether the sum, the carry, the overflow or the half-carry has the correct value. Only the bench can show that, by comparing every field against an independent integer model. Its scenarios cover wrap-around at 0xFFFF, signed overflow in both directions, the borrow chain at zero, a carry out of bit 11 and pass-through with arbitrary flags.

// File: rtl/rpa_pkg.sv
// Package: shared types and flag-bit positions for the register-pair adder.
// Assumes an 8-bit flag byte. The positions below are fixed by the datapath
// that consumes the flags.
package rpa_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADC  = 2'd1,
        OP_SBC  = 2'd2,
        OP_PASS = 2'd3
    } rpa_op_e;

    localparam int FLAG_W = 8;
    localparam int FB_S   = 7;
    localparam int FB_Z   = 6;
    localparam int FB_R5  = 5;
    localparam int FB_H   = 4;
    localparam int FB_R3  = 3;
    localparam int FB_V   = 2;
    localparam int FB_N   = 1;
    localparam int FB_C   = 0;
endpackage

// File: rtl/rpa_core_adder.sv
// Module: ripple-free behavioural carry adder with optional operand inversion.
// Computes a + (b or ~b) + cin over WIDTH bits and returns the carry out.
// Assumes the caller supplies an already mode-corrected carry in.
module rpa_core_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             inv_b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [EXT_W-1:0] wide;

    // Select the true or inverted right operand.
    always_comb b_eff = inv_b_i ? ~b_i : b_i;

    // One extended add produces sum and carry together.
    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = wide[WIDTH-1:0];
        cout_o = wide[WIDTH];
    end
endmodule

// File: rtl/rpa_flag_unit.sv
// Module: builds the outgoing flag byte for the three arithmetic modes.
// Assumes sum_i is the raw adder output and cout_i its raw carry. For subtract
// the adder ran with inverted src, so the borrow is the inverted carry.
// Pass-through mode is handled by the caller; the value produced here for it
// is not used.
module rpa_flag_unit
    import rpa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  rpa_op_e            op_i,
    input  logic [WIDTH-1:0]   dst_i,
    input  logic [WIDTH-1:0]   src_i,
    input  logic [WIDTH-1:0]   sum_i,
    input  logic               cout_i,
    input  logic [FLAG_W-1:0]  flags_i,
    output logic [FLAG_W-1:0]  flags_o
);
    localparam int MSB  = WIDTH - 1;
    localparam int HBIT = WIDTH - 4;

    logic [WIDTH-1:0] carry_vec;
    logic             ovf_add;
    logic             ovf_sub;
    logic             is_zero;

    // Per-bit carry-in vector of the operation, used for the half-carry.
    always_comb carry_vec = dst_i ^ src_i ^ sum_i;

    // Signed overflow for add and for subtract, from the operand signs.
    always_comb begin
        ovf_add = (~(dst_i[MSB] ^ src_i[MSB])) & (sum_i[MSB] ^ dst_i[MSB]);
        ovf_sub = (dst_i[MSB] ^ src_i[MSB]) & (sum_i[MSB] ^ dst_i[MSB]);
        is_zero = (sum_i == '0);
    end

    // Assemble the flag byte per mode; unused bits stay clear.
    always_comb begin
        flags_o        = '0;
        flags_o[FB_H]  = carry_vec[HBIT];
        unique case (op_i)
            OP_ADD: begin
                flags_o[FB_S] = flags_i[FB_S];
                flags_o[FB_Z] = flags_i[FB_Z];
                flags_o[FB_V] = flags_i[FB_V];
                flags_o[FB_C] = cout_i;
            end
            OP_ADC: begin
                flags_o[FB_S] = sum_i[MSB];
                flags_o[FB_Z] = is_zero;
                flags_o[FB_V] = ovf_add;
                flags_o[FB_C] = cout_i;
            end
            OP_SBC: begin
                flags_o[FB_S] = sum_i[MSB];
                flags_o[FB_Z] = is_zero;
                flags_o[FB_V] = ovf_sub;
                flags_o[FB_N] = 1'b1;
                flags_o[FB_C] = ~cout_i;
            end
            default: flags_o = flags_i;
        endcase
    end
endmodule

// File: rtl/reg_pair_adder.sv
// Module: top of the register-pair adder. Fully combinational.
// Drives the shared adder with a mode-dependent operand inversion and
// carry in, and selects between the arithmetic and pass-through outputs.
// Assumes bit 0 of the incoming flags is the carry (or borrow) in.
module reg_pair_adder
    import rpa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [15:0] dst_i,
    input  logic [15:0] src_i,
    input  logic [7:0]  flags_i,
    input  logic [1:0]  op_sel_i,
    output logic [15:0] result_o,
    output logic [7:0]  flags_o
);
    rpa_op_e          op;
    logic             inv_b;
    logic             cin_eff;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [7:0]       arith_flags;

    // Decode the select and derive adder controls.
    always_comb begin
        op      = rpa_op_e'(op_sel_i);
        inv_b   = (op == OP_SBC);
        unique case (op)
            OP_ADC:  cin_eff = flags_i[FB_C];
            OP_SBC:  cin_eff = ~flags_i[FB_C];
            default: cin_eff = 1'b0;
        endcase
    end

    rpa_core_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (dst_i),
        .b_i    (src_i),
        .inv_b_i(inv_b),
        .cin_i  (cin_eff),
        .sum_o  (sum),
        .cout_o (cout)
    );

    rpa_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .op_i   (op),
        .dst_i  (dst_i),
        .src_i  (src_i),
        .sum_i  (sum),
        .cout_i (cout),
        .flags_i(flags_i),
        .flags_o(arith_flags)
    );

    // Output select: pass-through bypasses the arithmetic path.
    always_comb begin
        if (op == OP_PASS) begin
            result_o = dst_i;
            flags_o  = flags_i;
        end else begin
            result_o = sum;
            flags_o  = arith_flags;
        end
    end

    // Guards relating the result port to the flag port.
    always_comb begin
        if (op_sel_i == 2'd0) begin
            a_r2_keep_szv: assert (flags_o[FB_S] == flags_i[FB_S] &&
                                   flags_o[FB_Z] == flags_i[FB_Z] &&
                                   flags_o[FB_V] == flags_i[FB_V] &&
                                   !flags_o[FB_N]);
        end
        if (op_sel_i == 2'd1 || op_sel_i == 2'd2) begin
            a_r4_zero_sign: assert (flags_o[FB_Z] == (result_o == 16'h0000) &&
                                    flags_o[FB_S] == result_o[15]);
        end
        if (op_sel_i != 2'd3) begin
            a_r9_unused_clear: assert (!flags_o[FB_R5] && !flags_o[FB_R3]);
        end
        if (op_sel_i == 2'd2) begin
            a_r6_sub_marker: assert (flags_o[FB_N]);
        end
    end
endmodule

// File: tb/test_reg_pair_adder.sv
module test_reg_pair_adder;
    logic        clk = 1'b0;
    logic [15:0] dst, src, res;
    logic [7:0]  fin, fout;
    logic [1:0]  op;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    reg_pair_adder i_reg_pair_adder (
        .dst_i(dst), .src_i(src), .flags_i(fin), .op_sel_i(op),
        .result_o(res), .flags_o(fout)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (op=%0d dst=%h src=%h f=%h)",
                     tag, act, exp, op, dst, src, fin);
        end
    endtask

    // Behavioural model with integers, then per-field comparison.
    task automatic apply(input int d, input int s, input int f, input int m);
        int r, c, h, v, n, z, sg, sum;
        string tr, tc, tsz, tv, tn;
        @(posedge clk);
        dst = d[15:0]; src = s[15:0]; fin = f[7:0]; op = m[1:0];
        @(negedge clk);
        c = 0; v = 0; n = 0;
        case (m)
            0: begin sum = d + s; r = sum & 'hFFFF; c = (sum >> 16) & 1;
                     tr = "R1"; tc = "R1"; tsz = "R2"; tv = "R2"; tn = "R2"; end
            1: begin sum = d + s + (f & 1); r = sum & 'hFFFF; c = (sum >> 16) & 1;
                     v = ((~(d ^ s) & (r ^ d)) >> 15) & 1;
                     tr = "R3"; tc = "R3"; tsz = "R4"; tv = "R5"; tn = "R9"; end
            2: begin sum = d - s - (f & 1); r = sum & 'hFFFF; c = (sum < 0) ? 1 : 0;
                     v = (((d ^ s) & (r ^ d)) >> 15) & 1; n = 1;
                     tr = "R6"; tc = "R6"; tsz = "R4"; tv = "R7"; tn = "R6"; end
            default: begin r = d; tr = "R10"; end
        endcase
        if (m == 3) begin
            cmp("R10 result", int'(res), d);
            cmp("R10 flags", int'(fout), f);
        end else begin
            h  = ((d ^ s ^ r) >> 12) & 1;
            z  = (r == 0) ? 1 : 0;
            sg = (r >> 15) & 1;
            if (m == 0) begin
                sg = (f >> 7) & 1; z = (f >> 6) & 1; v = (f >> 2) & 1;
            end
            cmp({tr, " result"}, int'(res), r);
            cmp({tc, " carry"}, int'(fout[0]), c);
            cmp({tsz, " sign"}, int'(fout[7]), sg);
            cmp({tsz, " zero"}, int'(fout[6]), z);
            cmp({tv, " overflow"}, int'(fout[2]), v);
            cmp({tn, " subtract"}, int'(fout[1]), n);
            cmp("R8 half", int'(fout[4]), h);
            cmp("R9 unused", int'({fout[5], fout[3]}), 0);
        end
    endtask

    initial begin
        dst = '0; src = '0; fin = '0; op = 2'd3;
        // Initial state: pass-through of all-zero inputs (R10).
        @(negedge clk);
        cmp("R10 initial result", int'(res), 0);
        cmp("R10 initial flags", int'(fout), 0);
        // R1/R2: wrap to zero, preserved S/Z/V, carry out.
        apply('hFFFF, 'h0001, 'hC4, 0);
        apply('h1234, 'h1111, 'h00, 0);
        apply('h0FFF, 'h0001, 'hFF, 0);    // R8 carry out of bit 11
        // R3/R5: overflow on positive+positive, carry-in wrap to zero.
        apply('h7FFF, 'h0000, 'h01, 1);
        apply('hFFFF, 'h0000, 'h01, 1);
        apply('h8000, 'h8000, 'h00, 1);
        // R6/R7: borrow chain at zero, negative overflow.
        apply('h0000, 'h0000, 'h01, 2);
        apply('h8000, 'h0001, 'h00, 2);
        apply('h1000, 'h0001, 'h00, 2);   // R8 borrow out of bit 11
        apply('h5555, 'h5555, 'h00, 2);
        // R10: arbitrary flags pass unchanged.
        apply('hBEEF, 'h1234, 'hA5, 3);
        for (int i = 0; i < 3000; i++)
            apply(int'($urandom & 'hFFFF), int'($urandom & 'hFFFF),
                  int'($urandom & 'hFF), int'($urandom & 3));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule